// File: doc/BRIEF.md
# I2C Slave with Host-Controlled Clock Stretching

This block is an I2C slave that can both receive and transmit. It shares one byte-wide data buffer with the host logic beside it. The host picks 7-bit or 10-bit addressing with a 4-bit mode field and supplies the slave's own address. The block watches SCL and SDA through synchronizers and detects START and STOP conditions. It matches the incoming address, acknowledges it, and shifts data bytes in or out MSB first. Every acknowledged byte it receives lands in the shared buffer, and a full flag tells the host there is something to read.

When a master asks to read, the slave acknowledges the address and then holds SCL low. It keeps holding until the host has loaded the buffer and set the release flag. The same hold is applied after every byte that the master acknowledges. Two sticky flags record misuse, and only a host clear pulse resets either one:
- The overflow flag records a byte that arrived while the previous byte was still unread.
- The collision flag records a buffer write while a loaded byte was still going out.

The pins belong to the serial logic only while the port is enabled with a slave mode selected. At other times the pull outputs stay inactive and the pins are free for other use.

Top module: `i2cs_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. If the address byte does not match, the slave leaves SDA undriven in the ninth clock (no ACK), and buf_full stays unchanged until the next START.
- R2: With mode 4'b0110 (7-bit), bits 7:1 of the first byte are compared with own_addr[6:0], and bit 0 is R/W (1 = read). On a match the slave pulls SDA low during the ninth clock, copies the address byte into the buffer and sets buf_full.
- R3: A write-direction byte that completes while buf_full is 1 gets no ACK. It sets ovf_flag and leaves the buffer holding the previous byte. ovf_flag then stays 1 until a clr_ovf pulse.
- R4: With mode 4'b0111 (10-bit), a header of 5'b11110, then own_addr[9:8], then R/W = 0 is ACKed. The next byte is ACKed only if it equals own_addr[7:0]. A header with R/W = 1 after a repeated START is ACKed only if the full write address has matched since the last STOP.
- R5: After ACKing a read address, the slave clears rel_flag at the end of the ACK clock. It then keeps scl_pull at 1, so the bus SCL stays low, until the host pulses rel_set.
- R6: In transmit, a byte written to the buffer during the stretch goes out MSB first, and buf_full clears after its eighth bit. If the master ACKs, the slave clears rel_flag and stretches again. If the master NACKs, the slave releases SDA and waits for a START or STOP.
- R7: A buf_wr while a loaded transmit byte has not yet finished its acknowledge clock sets wcol_flag and leaves the buffer unchanged. wcol_flag stays 1 until a clr_wcol pulse.
- R8: A read address that matches while buf_full is 1 is still ACKed, and ovf_flag is not set.
- R9: pins_owned is 1 only when port_en is 1 and mode is 4'b0110 or 4'b0111. Otherwise scl_pull and sda_pull stay 0 and the slave does not respond.
- R10: After reset, buf_full, ovf_flag and wcol_flag are 0, rel_flag is 1, both pull outputs are 0 and the buffer reads 8'h00.
- R11: A buf_rd pulse clears buf_full. The next write-direction data byte is then ACKed and stored in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Hands the pins to the serial logic |
| mode | input | 4 | Mode code: 0110 is 7-bit slave, 0111 is 10-bit slave |
| own_addr | input | 10 | Slave address; 7-bit mode uses bits 6:0 |
| buf_wr | input | 1 | Host write pulse for the shared buffer |
| buf_wdata | input | 8 | Host write data |
| buf_rd | input | 1 | Host read pulse, clears buf_full |
| buf_rdata | output | 8 | Current buffer contents |
| rel_set | input | 1 | Host pulse that sets the clock-release flag |
| clr_ovf | input | 1 | Host pulse that clears ovf_flag |
| clr_wcol | input | 1 | Host pulse that clears wcol_flag |
| buf_full | output | 1 | Buffer holds an unread or unsent byte |
| ovf_flag | output | 1 | Sticky receive-overflow flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| rel_flag | output | 1 | Clock-release flag; 0 holds SCL low |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_pull | output | 1 | 1 drives SCL low |
| sda_pull | output | 1 | 1 drives SDA low |
| pins_owned | output | 1 | Pins are under serial-port control |

## Verification
The bench builds the slave with three synchronizer stages rather than the default two. The extra stage of latency must still fit inside each quarter of the bit period, so every drive and sample decision is tested against the slowest setting the timing allows. The own-address values are chosen so that a table of single-byte transactions reaches both address widths, an all-ones 7-bit address, a mismatch in one low bit, a mismatch in the 10-bit high bits and an unsupported mode code. The directed tests then cover the transmit handshake with its repeated stretches, the overflow and collision paths, and the rule that a read header requires a prior full 10-bit match.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    localparam logic [3:0] MODE_SLV7  = 4'b0110;
    localparam logic [3:0] MODE_SLV10 = 4'b0111;
    localparam logic [4:0] HDR10      = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BITS,
        PH_ACK,
        PH_MACK,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        RL_ADDR1,
        RL_ADDR2,
        RL_RX,
        RL_TX
    } role_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic  match;
        logic  to_tx;
        logic  set_hi;
        role_e next_role;
    } addr_dec_t;

    function automatic addr_dec_t decode_byte(
        input role_e             role,
        input logic              ten_bit,
        input logic              hi_ok,
        input logic [DATA_W-1:0] b,
        input logic [ADDR_W-1:0] own
    );
        addr_dec_t d;
        logic      hdr_hit;
        d.match     = 1'b0;
        d.to_tx     = 1'b0;
        d.set_hi    = 1'b0;
        d.next_role = RL_RX;
        hdr_hit = (b[7:3] == HDR10) && (b[2:1] == own[9:8]);
        case (role)
            RL_ADDR1: begin
                if (!ten_bit) begin
                    d.match     = (b[7:1] == own[6:0]);
                    d.to_tx     = b[0];
                    d.next_role = b[0] ? RL_TX : RL_RX;
                end else if (!b[0]) begin
                    d.match     = hdr_hit;
                    d.next_role = RL_ADDR2;
                end else begin
                    d.match     = hdr_hit && hi_ok;
                    d.to_tx     = 1'b1;
                    d.next_role = RL_TX;
                end
            end
            RL_ADDR2: begin
                d.match     = (b == own[7:0]);
                d.set_hi    = d.match;
                d.next_role = RL_RX;
            end
            RL_RX: begin
                d.match     = 1'b1;
                d.next_role = RL_RX;
            end
            default: begin
                d.match     = 1'b0;
                d.next_role = RL_TX;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    localparam int LINES = 2;
    localparam int SCL_I = 1;
    localparam int SDA_I = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.scl      = synced[SCL_I];
        ev.sda      = synced[SDA_I];
        ev.scl_rise = synced[SCL_I] & ~prev[SCL_I];
        ev.scl_fall = ~synced[SCL_I] & prev[SCL_I];
        ev.start    = synced[SCL_I] & prev[SCL_I] & prev[SDA_I] & ~synced[SDA_I];
        ev.stop     = synced[SCL_I] & prev[SCL_I] & ~prev[SDA_I] & synced[SDA_I];
    end

endmodule

// File: rtl/i2cs_bus_fsm.sv
module i2cs_bus_fsm
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  line_ev_t          ev,
    input  logic              buf_full,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sda_drive,
    output logic              store,
    output logic [DATA_W-1:0] store_byte,
    output logic              ovf_set,
    output logic              rel_clr,
    output logic              tx_busy,
    output logic              tx_ready,
    output logic              tx_done
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    phase_e            phase;
    role_e             role;
    role_e             next_role_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-2:0] shreg;
    logic [DATA_W-1:0] txsh;
    logic              armed;
    logic              ack_q;
    logic              ack_drv;
    logic              hi_ok;
    logic              mack_ok;

    logic [DATA_W-1:0] rx_byte;
    addr_dec_t         dec;
    logic              will_ack;
    logic              in_tx_bits;

    assign rx_byte = {shreg, ev.sda};

    always_comb begin
        dec      = decode_byte(role, ten_bit, hi_ok, rx_byte, own_addr);
        will_ack = dec.match && (dec.to_tx || !buf_full);
    end

    assign in_tx_bits = (phase == PH_BITS) && (role == RL_TX);
    assign sda_drive  = ack_drv | (in_tx_bits & armed & ~txsh[DATA_W-1]);
    assign tx_busy    = armed;
    assign tx_ready   = in_tx_bits & ~armed;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase       <= PH_IDLE;
            role        <= RL_ADDR1;
            next_role_q <= RL_ADDR1;
            cnt         <= '0;
            shreg       <= '0;
            txsh        <= '0;
            armed       <= 1'b0;
            ack_q       <= 1'b0;
            ack_drv     <= 1'b0;
            hi_ok       <= 1'b0;
            mack_ok     <= 1'b0;
            store       <= 1'b0;
            store_byte  <= '0;
            ovf_set     <= 1'b0;
            rel_clr     <= 1'b0;
            tx_done     <= 1'b0;
        end else begin
            store   <= 1'b0;
            ovf_set <= 1'b0;
            rel_clr <= 1'b0;
            tx_done <= 1'b0;

            if (ev.stop) begin
                phase   <= PH_IDLE;
                hi_ok   <= 1'b0;
                armed   <= 1'b0;
                ack_drv <= 1'b0;
            end else if (ev.start) begin
                phase   <= PH_BITS;
                role    <= RL_ADDR1;
                cnt     <= '0;
                armed   <= 1'b0;
                ack_drv <= 1'b0;
            end else begin
                case (phase)
                    PH_BITS: begin
                        if (role != RL_TX) begin
                            if (ev.scl_rise) begin
                                shreg <= rx_byte[DATA_W-2:0];
                                cnt   <= cnt + 1'b1;
                                if (cnt == LAST_BIT) begin
                                    ack_q       <= will_ack;
                                    store       <= will_ack;
                                    store_byte  <= rx_byte;
                                    ovf_set     <= dec.match && !dec.to_tx && buf_full;
                                    next_role_q <= dec.next_role;
                                    if (dec.set_hi && will_ack) hi_ok <= 1'b1;
                                end
                            end else if (ev.scl_fall && cnt == FULL_CNT) begin
                                if (ack_q) begin
                                    phase   <= PH_ACK;
                                    ack_drv <= 1'b1;
                                end else begin
                                    phase <= PH_SKIP;
                                end
                            end
                        end else if (armed) begin
                            if (ev.scl_rise) begin
                                cnt <= cnt + 1'b1;
                            end else if (ev.scl_fall && cnt != '0) begin
                                txsh <= {txsh[DATA_W-2:0], 1'b0};
                                if (cnt == FULL_CNT) begin
                                    phase   <= PH_MACK;
                                    tx_done <= 1'b1;
                                end
                            end
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            ack_drv <= 1'b0;
                            phase   <= PH_BITS;
                            role    <= next_role_q;
                            cnt     <= '0;
                            if (next_role_q == RL_TX) rel_clr <= 1'b1;
                        end
                    end
                    PH_MACK: begin
                        if (ev.scl_rise) begin
                            mack_ok <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            armed <= 1'b0;
                            if (mack_ok) begin
                                phase   <= PH_BITS;
                                cnt     <= '0;
                                rel_clr <= 1'b1;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end

            if (tx_load) begin
                txsh  <= tx_data;
                armed <= 1'b1;
            end
        end
    end

    // R1: the slave never moves SDA while SCL stays high outside START/STOP
    // handling and host loads.
    assert_sda_steady_R1: assert property (@(posedge clk) disable iff (rst || !active)
        (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop) && !$past(tx_load))
        |-> $stable(sda_drive));

    // R8: a transmit-role byte never raises the overflow request.
    assert_no_ovf_in_tx_R8: assert property (@(posedge clk) disable iff (rst || !active)
        (role == RL_TX && phase != PH_IDLE) |=> !ovf_set);

endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              rel_set,
    input  logic              clr_ovf,
    input  logic              clr_wcol,
    input  logic              store,
    input  logic [DATA_W-1:0] store_byte,
    input  logic              ovf_set,
    input  logic              rel_clr,
    input  logic              tx_busy,
    input  logic              tx_ready,
    input  logic              tx_done,
    output logic [DATA_W-1:0] buf_q,
    output logic              full_q,
    output logic              ovf_q,
    output logic              wcol_q,
    output logic              rel_q,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data
);

    logic wr_ok;
    logic wcol_hit;

    assign wr_ok    = buf_wr && !tx_busy && !store;
    assign wcol_hit = buf_wr && tx_busy;
    assign tx_load  = wr_ok && tx_ready;
    assign tx_data  = buf_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
            wcol_q <= 1'b0;
            rel_q  <= 1'b1;
        end else begin
            if (store) begin
                buf_q  <= store_byte;
                full_q <= 1'b1;
            end else if (wr_ok) begin
                buf_q <= buf_wdata;
                if (tx_ready) full_q <= 1'b1;
            end else if (tx_done || buf_rd) begin
                full_q <= 1'b0;
            end

            if (ovf_set)      ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;

            if (wcol_hit)      wcol_q <= 1'b1;
            else if (clr_wcol) wcol_q <= 1'b0;

            if (rel_set)      rel_q <= 1'b1;
            else if (rel_clr) rel_q <= 1'b0;
        end
    end

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_ovf) |=> ovf_q);

    assert_wcol_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (wcol_q && !clr_wcol) |=> wcol_q);

    assert_wcol_keeps_buf_R7: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && tx_busy && !store) |=> $stable(buf_q));

    assert_hold_until_release_R5: assert property (@(posedge clk) disable iff (rst)
        (!rel_q && !rel_set) |=> !rel_q);

    assert_store_sets_full_R2: assert property (@(posedge clk) disable iff (rst)
        store |=> full_q);

endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              rel_set,
    input  logic              clr_ovf,
    input  logic              clr_wcol,
    output logic              buf_full,
    output logic              ovf_flag,
    output logic              wcol_flag,
    output logic              rel_flag,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              pins_owned
);

    logic              active;
    logic              ten_bit;
    line_ev_t          ev;
    logic              sda_drive;
    logic              store;
    logic [DATA_W-1:0] store_byte;
    logic              ovf_set;
    logic              rel_clr;
    logic              tx_busy;
    logic              tx_ready;
    logic              tx_done;
    logic              tx_load;
    logic [DATA_W-1:0] tx_data;

    assign ten_bit = (mode == MODE_SLV10);
    assign active  = port_en && ((mode == MODE_SLV7) || ten_bit);

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cs_bus_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .ten_bit    (ten_bit),
        .own_addr   (own_addr),
        .ev         (ev),
        .buf_full   (buf_full),
        .tx_load    (tx_load),
        .tx_data    (tx_data),
        .sda_drive  (sda_drive),
        .store      (store),
        .store_byte (store_byte),
        .ovf_set    (ovf_set),
        .rel_clr    (rel_clr),
        .tx_busy    (tx_busy),
        .tx_ready   (tx_ready),
        .tx_done    (tx_done)
    );

    i2cs_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .buf_rd     (buf_rd),
        .rel_set    (rel_set),
        .clr_ovf    (clr_ovf),
        .clr_wcol   (clr_wcol),
        .store      (store),
        .store_byte (store_byte),
        .ovf_set    (ovf_set),
        .rel_clr    (rel_clr),
        .tx_busy    (tx_busy),
        .tx_ready   (tx_ready),
        .tx_done    (tx_done),
        .buf_q      (buf_rdata),
        .full_q     (buf_full),
        .ovf_q      (ovf_flag),
        .wcol_q     (wcol_flag),
        .rel_q      (rel_flag),
        .tx_load    (tx_load),
        .tx_data    (tx_data)
    );

    assign pins_owned = active;
    assign scl_pull   = active & ~rel_flag;
    assign sda_pull   = active & sda_drive;

    // R5: a stretch is only ever started by the engine's release-clear request.
    assert_stretch_needs_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && $rose(scl_pull)) |-> $past(rel_clr));

endmodule

// File: tb/i2cs_slave_bench.sv
`timescale 1ns/1ps
module i2cs_slave_bench;

    localparam int Q    = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [3:0] mode;
        logic [9:0] own;
        logic [7:0] byt;
        logic       ack;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{4'b0110, 10'h03A, 8'h74, 1'b1},
        '{4'b0110, 10'h03A, 8'h76, 1'b0},
        '{4'b0110, 10'h055, 8'hAA, 1'b1},
        '{4'b0101, 10'h03A, 8'h74, 1'b0},
        '{4'b0111, 10'h23A, 8'hF4, 1'b1},
        '{4'b0111, 10'h13A, 8'hF4, 1'b0},
        '{4'b0110, 10'h07F, 8'hFE, 1'b1},
        '{4'b0110, 10'h07F, 8'hFC, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0;
    logic [3:0] mode = 4'b0110;
    logic [9:0] own_addr = 10'h03A;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic       buf_rd = 1'b0;
    logic [7:0] buf_rdata;
    logic       rel_set = 1'b0;
    logic       clr_ovf = 1'b0;
    logic       clr_wcol = 1'b0;
    logic       buf_full, ovf_flag, wcol_flag, rel_flag;
    logic       scl_pull, sda_pull, pins_owned;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_line, sda_line;

    int n_checks = 0;
    int n_fail   = 0;

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    i2cs_slave #(.SYNC_STAGES(3)) u_i2cs_slave (
        .clk        (clk),
        .rst        (rst),
        .port_en    (port_en),
        .mode       (mode),
        .own_addr   (own_addr),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .buf_rd     (buf_rd),
        .buf_rdata  (buf_rdata),
        .rel_set    (rel_set),
        .clr_ovf    (clr_ovf),
        .clr_wcol   (clr_wcol),
        .buf_full   (buf_full),
        .ovf_flag   (ovf_flag),
        .wcol_flag  (wcol_flag),
        .rel_flag   (rel_flag),
        .scl_in     (scl_line),
        .sda_in     (sda_line),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .pins_owned (pins_owned)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        while (scl_line !== 1'b1 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 4000) check("R5 stretch never released", 16'(scl_line), 16'h1);
    endtask

    task automatic clock_bit(input logic b, output logic got);
        sda_m = b;
        wait_q(Q);
        scl_m = 1'b1;
        wait_scl_high();
        wait_q(Q);
        got = sda_line;
        wait_q(Q);
        scl_m = 1'b0;
        wait_q(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_q(Q);
        scl_m = 1'b1;
        wait_scl_high();
        wait_q(Q);
        sda_m = 1'b0;
        wait_q(Q);
        scl_m = 1'b0;
        wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_q(Q);
        scl_m = 1'b1;
        wait_scl_high();
        wait_q(Q);
        sda_m = 1'b1;
        wait_q(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic g;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], g);
        clock_bit(1'b1, g);
        acked = ~g;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] d);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, g);
            d[i] = g;
        end
        clock_bit(~master_ack, g);
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        buf_wdata = d;
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rel();
        rel_set = 1'b1;
        @(negedge clk);
        rel_set = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       ak;
        logic [7:0] rd;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check("R10 buf_full", 16'(buf_full), 16'h0);
        check("R10 ovf_flag", 16'(ovf_flag), 16'h0);
        check("R10 wcol_flag", 16'(wcol_flag), 16'h0);
        check("R10 rel_flag", 16'(rel_flag), 16'h1);
        check("R10 pulls", 16'({scl_pull, sda_pull}), 16'h0);
        check("R10 buffer", 16'(buf_rdata), 16'h00);

        port_en = 1'b1;

        // Table walk: R1 / R2 / R4 / R9 single-address transactions
        for (int v = 0; v < NVEC; v++) begin
            mode = VECS[v].mode;
            own_addr = VECS[v].own;
            wait_q(Q);
            check("R9 pins_owned", 16'(pins_owned),
                  16'((VECS[v].mode == 4'b0110) || (VECS[v].mode == 4'b0111)));
            bus_start();
            send_byte(VECS[v].byt, ak);
            check("R1 R2 R4 address ack", 16'(ak), 16'(VECS[v].ack));
            check("R1 R2 buf_full after address", 16'(buf_full), 16'(VECS[v].ack));
            if (VECS[v].ack) begin
                check("R2 address byte in buffer", 16'(buf_rdata), 16'(VECS[v].byt));
                pulse_rd();
            end
            bus_stop();
        end

        // R2 / R11: 7-bit write with two data bytes
        mode = 4'b0110;
        own_addr = 10'h03A;
        wait_q(Q);
        bus_start();
        send_byte(8'h74, ak);
        check("R2 write address ack", 16'(ak), 16'h1);
        pulse_rd();
        check("R11 read clears full", 16'(buf_full), 16'h0);
        send_byte(8'hC3, ak);
        check("R11 data ack", 16'(ak), 16'h1);
        check("R11 data stored", 16'(buf_rdata), 16'h00C3);
        pulse_rd();
        bus_stop();

        // R3: overflow
        bus_start();
        send_byte(8'h74, ak);
        send_byte(8'h11, ak);
        check("R3 overflow byte not acked", 16'(ak), 16'h0);
        check("R3 ovf_flag set", 16'(ovf_flag), 16'h1);
        check("R3 old byte kept", 16'(buf_rdata), 16'h0074);
        bus_stop();
        wait_q(4 * Q);
        check("R3 ovf_flag sticky", 16'(ovf_flag), 16'h1);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        @(negedge clk);
        check("R3 ovf_flag cleared", 16'(ovf_flag), 16'h0);
        pulse_rd();

        // R4 / R5 / R6: 10-bit write then read via repeated START
        mode = 4'b0111;
        own_addr = 10'h23A;
        wait_q(Q);
        bus_start();
        send_byte(8'hF4, ak);
        check("R4 header ack", 16'(ak), 16'h1);
        pulse_rd();
        send_byte(8'h3A, ak);
        check("R4 low byte ack", 16'(ak), 16'h1);
        pulse_rd();
        send_byte(8'h5C, ak);
        check("R4 data ack", 16'(ak), 16'h1);
        check("R4 data stored", 16'(buf_rdata), 16'h005C);
        pulse_rd();
        bus_start();
        send_byte(8'hF5, ak);
        check("R4 read header ack", 16'(ak), 16'h1);
        check("R5 rel_flag cleared", 16'(rel_flag), 16'h0);
        check("R5 scl held", 16'(scl_pull), 16'h1);
        scl_m = 1'b1;
        wait_q(2 * Q);
        check("R5 bus SCL low while stretched", 16'(scl_line), 16'h0);
        pulse_wr(8'hA6);
        check("R7 no collision on first load", 16'(wcol_flag), 16'h0);
        pulse_rel();
        recv_byte(1'b0, rd);
        check("R6 transmitted byte", 16'(rd), 16'h00A6);
        check("R6 full cleared after send", 16'(buf_full), 16'h0);
        check("R6 no stretch after nack", 16'(scl_pull), 16'h0);
        bus_stop();
        check("R6 sda released", 16'(sda_pull), 16'h0);

        // R4: low-byte mismatch and read header without prior match
        bus_start();
        send_byte(8'hF4, ak);
        pulse_rd();
        send_byte(8'h3B, ak);
        check("R4 low byte mismatch nack", 16'(ak), 16'h0);
        bus_stop();
        bus_start();
        send_byte(8'hF5, ak);
        check("R4 read header without match nack", 16'(ak), 16'h0);
        bus_stop();

        // R8 / R7 / R6: 7-bit read with full buffer, collision, two bytes
        mode = 4'b0110;
        own_addr = 10'h03A;
        wait_q(Q);
        bus_start();
        send_byte(8'h74, ak);
        check("R8 buffer full before read", 16'(buf_full), 16'h1);
        bus_start();
        send_byte(8'h75, ak);
        check("R8 read ack with full buffer", 16'(ak), 16'h1);
        check("R8 ovf stays clear", 16'(ovf_flag), 16'h0);
        pulse_rd();
        pulse_wr(8'h96);
        pulse_wr(8'h00);
        check("R7 collision flagged", 16'(wcol_flag), 16'h1);
        check("R7 buffer unchanged", 16'(buf_rdata), 16'h0096);
        pulse_rel();
        recv_byte(1'b1, rd);
        check("R6 first read byte", 16'(rd), 16'h0096);
        check("R6 stretch after master ack", 16'(scl_pull), 16'h1);
        check("R6 rel cleared again", 16'(rel_flag), 16'h0);
        pulse_wr(8'h3C);
        pulse_rel();
        recv_byte(1'b0, rd);
        check("R6 second read byte", 16'(rd), 16'h003C);
        bus_stop();
        check("R7 wcol sticky", 16'(wcol_flag), 16'h1);
        check("R8 ovf after transmit", 16'(ovf_flag), 16'h0);
        clr_wcol = 1'b1;
        @(negedge clk);
        clr_wcol = 1'b0;
        @(negedge clk);
        check("R7 wcol cleared", 16'(wcol_flag), 16'h0);

        // R9: port disabled
        port_en = 1'b0;
        wait_q(Q);
        check("R9 pins released", 16'(pins_owned), 16'h0);
        bus_start();
        send_byte(8'h74, ak);
        check("R9 no ack when disabled", 16'(ak), 16'h0);
        check("R9 buffer not filled", 16'(buf_full), 16'h0);
        bus_stop();

        finish_run();
    end

endmodule